// File: doc/BRIEF.md
# Paired X/Y Word Memory Bridge

This block lets a host with a narrow byte-wide register port move paired 16-bit words into and out of two internal memory banks: a data bank and a coefficient bank. Each bank holds an X array and a Y array, and an access always touches both arrays at the same location. The host assembles each 16-bit word from a low byte register and a high byte register. It picks the location with an address byte plus one extension bit, chooses a bank, chooses read or write, and then raises a request bit.

There are two channels, and they do not depend on each other. Each channel has its own six host registers, and both channels reach the same two banks. Each request produces exactly one transfer, and the hardware clears the request bit when that transfer finishes. A transfer takes two clock edges. At the first edge it is granted, and the memory is written or read. At the second edge it completes: read data lands in the channel's byte registers and the request bit drops.

When both channels wait at the same time, channel 0 is served first. Channel 1 is granted in the cycle after channel 0's transfer completes. Channel 0 leaves reset with a pending read request. Arbitration against any other memory user is not part of this block.

Top module: `xy_coef_bridge`

## Requirements
- R1: The host register index `reg_addr` works as follows. Bit 3 selects the channel. Bits 2:0 select the sub-register: 0 is X low byte, 1 is X high byte, 2 is Y low byte, 3 is Y high byte, 4 is the address byte and 5 is control. Sub-registers 6 and 7 read as zero.
- R2: The control byte has four bits: bit 0 is the address extension, bit 1 is the bank (0 = data bank, 1 = coefficient bank), bit 2 is write (1) or read (0), and bit 3 is the request. Bits 7:4 read as zero.
- R3: While reset is held, channel 0 has address byte 0x17 and control 0x08 (request set, read, data bank). Channel 1 has address 0x00 and control 0x00.
- R4: A write request stores {X high, X low} into the X array and {Y high, Y low} into the Y array of the selected bank, at the location {extension, address byte}.
- R5: A read request loads the stored X and Y words of the selected bank and location into that channel's four byte registers.
- R6: The request bit is still set one half-cycle and one and a half cycles after the host edge that sets it. It reads clear two and a half cycles after that edge, so a request causes one transfer.
- R7: The two banks are separate: the same location in the data bank and in the coefficient bank holds independent values.
- R8: The extension bit is the most significant address bit: location 0x100+n is distinct from location n.
- R9: Both channels reach the same memories, so a word written by one channel is read back by the other.
- R10: When both requests are pending while the block is idle, channel 0 is granted first. Channel 1 keeps its request set until channel 0 completes, and is then served. A read by channel 1 therefore sees channel 0's write to the same location.
- R11: A host write to the control register in the same edge that completes that channel's transfer takes priority over the hardware clear. If that write sets the request, it starts a new request.
- R12: Writing byte, address or control registers without the request bit moves no data to or from memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_addr | input | 4 | Host register index: channel in bit 3, sub-register in bits 2:0 |
| reg_wr_en | input | 1 | Host write strobe, one byte per cycle |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Combinational read of the indexed register |

## Verification
The hardest state to reach is two requests pending together while the block is idle. The host port writes one byte per cycle, and a lone request is granted on the next edge. The bench reaches this state with three control writes on consecutive edges. The first sets channel 1's request. The second sets channel 0's request while channel 1 is busy. The third sets channel 1's request again on the very edge that completes its first transfer. Channel 1 reads the location that channel 0 writes, so the data it returns shows the order of service, and the request bits are sampled cycle by cycle to show the timing.

// File: rtl/xyb_pkg.sv
package xyb_pkg;
  typedef enum logic [2:0] {
    SUB_XL  = 3'd0,
    SUB_XH  = 3'd1,
    SUB_YL  = 3'd2,
    SUB_YH  = 3'd3,
    SUB_ADR = 3'd4,
    SUB_CTL = 3'd5
  } sub_e;

  localparam int CTL_EXT  = 0;
  localparam int CTL_BANK = 1;
  localparam int CTL_WR   = 2;
  localparam int CTL_REQ  = 3;

  localparam int NUM_CH   = 2;
  localparam int NUM_BANK = 2;
endpackage

// File: rtl/xyb_chan.sv
module xyb_chan
  import xyb_pkg::*;
#(
  parameter int             BW      = 8,
  parameter logic [BW-1:0]  RST_ADR = '0,
  parameter logic           RST_REQ = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  sub_e            sub,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  input  logic            done,
  input  logic            load,
  input  logic [2*BW-1:0] ld_x,
  input  logic [2*BW-1:0] ld_y,
  output logic [BW-1:0]   adr,
  output logic            ext,
  output logic            bank,
  output logic            wr,
  output logic            req,
  output logic [2*BW-1:0] x_word,
  output logic [2*BW-1:0] y_word
);
  localparam int WW = 2 * BW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_word <= '0;
      y_word <= '0;
      adr    <= RST_ADR;
      ext    <= 1'b0;
      bank   <= 1'b0;
      wr     <= 1'b0;
      req    <= RST_REQ;
    end else begin
      if (done) req <= 1'b0;
      if (host_we) begin
        unique case (sub)
          SUB_XL:  x_word[BW-1:0]  <= wdata;
          SUB_XH:  x_word[WW-1:BW] <= wdata;
          SUB_YL:  y_word[BW-1:0]  <= wdata;
          SUB_YH:  y_word[WW-1:BW] <= wdata;
          SUB_ADR: adr <= wdata;
          SUB_CTL: begin
            ext  <= wdata[CTL_EXT];
            bank <= wdata[CTL_BANK];
            wr   <= wdata[CTL_WR];
            req  <= wdata[CTL_REQ];
          end
          default: ;
        endcase
      end
      if (load) begin
        x_word <= ld_x;
        y_word <= ld_y;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sub)
      SUB_XL:  rdata = x_word[BW-1:0];
      SUB_XH:  rdata = x_word[WW-1:BW];
      SUB_YL:  rdata = y_word[BW-1:0];
      SUB_YH:  rdata = y_word[WW-1:BW];
      SUB_ADR: rdata = adr;
      SUB_CTL: begin
        rdata[CTL_EXT]  = ext;
        rdata[CTL_BANK] = bank;
        rdata[CTL_WR]   = wr;
        rdata[CTL_REQ]  = req;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/xyb_bank.sv
module xyb_bank #(
  parameter int AW = 9,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wx,
  input  logic [WW-1:0] wy,
  output logic [WW-1:0] rx,
  output logic [WW-1:0] ry
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem_x [DEPTH];
  logic [WW-1:0] mem_y [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_x[addr] <= wx;
      mem_y[addr] <= wy;
    end
    if (re) begin
      rx <= mem_x[addr];
      ry <= mem_y[addr];
    end
  end
endmodule

// File: rtl/xyb_arb.sv
module xyb_arb #(
  parameter int NCH = 2,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic           start,
  output logic [IDW-1:0] start_id,
  output logic           busy,
  output logic [IDW-1:0] owner
);
  logic found;

  always_comb begin
    found    = 1'b0;
    start_id = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found    = 1'b1;
        start_id = IDW'(i);
      end
    end
  end

  assign start = found && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      owner <= start_id;
    end else begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/xy_coef_bridge.sv
module xy_coef_bridge
  import xyb_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr_en,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata
);
  localparam int WW  = 2 * BW;
  localparam int AW  = BW + 1;
  localparam int NCH = NUM_CH;
  localparam int NBK = NUM_BANK;
  localparam int IDW = $clog2(NCH);

  logic [NCH-1:0][BW-1:0] ch_adr;
  logic [NCH-1:0][BW-1:0] ch_rdata;
  logic [NCH-1:0][WW-1:0] ch_x;
  logic [NCH-1:0][WW-1:0] ch_y;
  logic [NCH-1:0]         ch_ext;
  logic [NCH-1:0]         ch_bank;
  logic [NCH-1:0]         ch_wr;
  logic [NCH-1:0]         ch_req;

  logic                   start;
  logic [IDW-1:0]         start_id;
  logic                   busy;
  logic [IDW-1:0]         owner;
  logic                   op_wr;
  logic                   op_bank;
  logic [AW-1:0]          op_addr;

  logic [NBK-1:0][WW-1:0] bank_rx;
  logic [NBK-1:0][WW-1:0] bank_ry;
  logic [WW-1:0]          rd_x;
  logic [WW-1:0]          rd_y;

  sub_e sub;
  assign sub = sub_e'(reg_addr[2:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_we;
    logic done;
    assign sel_we = reg_wr_en && (reg_addr[3] == 1'(c));
    assign done   = busy && (owner == IDW'(c));

    xyb_chan #(
      .BW     (BW),
      .RST_ADR((c == 0) ? BW'(8'h17) : BW'(0)),
      .RST_REQ((c == 0) ? 1'b1 : 1'b0)
    ) i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .host_we(sel_we),
      .sub    (sub),
      .wdata  (reg_wdata),
      .rdata  (ch_rdata[c]),
      .done   (done),
      .load   (done && !op_wr),
      .ld_x   (rd_x),
      .ld_y   (rd_y),
      .adr    (ch_adr[c]),
      .ext    (ch_ext[c]),
      .bank   (ch_bank[c]),
      .wr     (ch_wr[c]),
      .req    (ch_req[c]),
      .x_word (ch_x[c]),
      .y_word (ch_y[c])
    );
  end

  xyb_arb #(.NCH(NCH)) i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (ch_req),
    .start   (start),
    .start_id(start_id),
    .busy    (busy),
    .owner   (owner)
  );

  assign op_addr = {ch_ext[start_id], ch_adr[start_id]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr   <= 1'b0;
      op_bank <= 1'b0;
    end else if (start) begin
      op_wr   <= ch_wr[start_id];
      op_bank <= ch_bank[start_id];
    end
  end

  for (genvar b = 0; b < NBK; b++) begin : g_bank
    logic hit;
    assign hit = start && (ch_bank[start_id] == 1'(b));

    xyb_bank #(.AW(AW), .WW(WW)) i_bank (
      .clk (clk),
      .we  (hit && ch_wr[start_id]),
      .re  (hit && !ch_wr[start_id]),
      .addr(op_addr),
      .wx  (ch_x[start_id]),
      .wy  (ch_y[start_id]),
      .rx  (bank_rx[b]),
      .ry  (bank_ry[b])
    );
  end

  assign rd_x      = bank_rx[op_bank];
  assign rd_y      = bank_ry[op_bank];
  assign reg_rdata = ch_rdata[reg_addr[3]];
endmodule

// File: rtl/xyb_checker.sv
module xyb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_wr_en,
  input logic        busy,
  input logic        owner,
  input logic        op_wr,
  input logic [1:0]  ch_req,
  input logic [15:0] x0_word,
  input logic [15:0] rd_x
);
  logic ctl_we0;
  logic ctl_we1;
  assign ctl_we0 = reg_wr_en && (reg_addr == 4'h5);
  assign ctl_we1 = reg_wr_en && (reg_addr == 4'hD);

  // R3: request state while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_rst_req_r3: assert (ch_req == 2'b01)
        else $error("reset request state wrong");
    end
  end

  p_ch0_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ch_req[0]) |=> (busy && owner == 1'b0));

  p_ch1_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ch_req == 2'b10) |=> (busy && owner == 1'b1));

  p_one_cycle_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_clear0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner == 1'b0 && !ctl_we0) |=> !ch_req[0]);

  p_clear1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner == 1'b1 && !ctl_we1) |=> !ch_req[1]);

  p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner == 1'b1 && ctl_we1) |=> ch_req[1] == $past(ch_req[1]));

  p_read_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_wr && owner == 1'b0) |=> (x0_word == $past(rd_x)));
endmodule

bind xy_coef_bridge xyb_checker i_xyb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr_en(reg_wr_en),
  .busy     (busy),
  .owner    (owner),
  .op_wr    (op_wr),
  .ch_req   (ch_req),
  .x0_word  (ch_x[0]),
  .rd_x     (rd_x)
);

// File: tb/test_xy_coef_bridge.sv
module test_xy_coef_bridge;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_run  = 0;
  int n_fail = 0;

  logic [15:0] mdl_x [2][512];
  logic [15:0] mdl_y [2][512];
  bit          mdl_ok [2][512];

  xy_coef_bridge i_xy_coef_bridge (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #(CLK_P / 2) clk = ~clk;

  function automatic logic [7:0] ctl(input bit ext, input bit bank, input bit wr, input bit req);
    return {4'b0, req, wr, bank, ext};
  endfunction

  function automatic logic [3:0] ra(input int ch, input int sub);
    return 4'((ch << 3) | sub);
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load_words(input int ch, input logic [15:0] x, input logic [15:0] y);
    hw(ra(ch, 0), x[7:0]);
    hw(ra(ch, 1), x[15:8]);
    hw(ra(ch, 2), y[7:0]);
    hw(ra(ch, 3), y[15:8]);
  endtask

  task automatic get_words(input int ch, output logic [15:0] x, output logic [15:0] y);
    logic [7:0] b0, b1, b2, b3;
    hr(ra(ch, 0), b0);
    hr(ra(ch, 1), b1);
    hr(ra(ch, 2), b2);
    hr(ra(ch, 3), b3);
    x = {b1, b0};
    y = {b3, b2};
  endtask

  task automatic wait_done(input int ch);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      hr(ra(ch, 5), c);
      if (!c[3]) break;
      @(negedge clk);
    end
    check("R6 request cleared", 32'(c[3]), 32'd0);
  endtask

  task automatic mem_write(input int ch, input bit bank, input logic [8:0] a,
                           input logic [15:0] x, input logic [15:0] y);
    load_words(ch, x, y);
    hw(ra(ch, 4), a[7:0]);
    hw(ra(ch, 5), ctl(a[8], bank, 1'b1, 1'b1));
    wait_done(ch);
    @(negedge clk);
    mdl_x[bank][a] = x;
    mdl_y[bank][a] = y;
    mdl_ok[bank][a] = 1'b1;
  endtask

  task automatic mem_read(input int ch, input bit bank, input logic [8:0] a,
                          output logic [15:0] x, output logic [15:0] y);
    hw(ra(ch, 4), a[7:0]);
    hw(ra(ch, 5), ctl(a[8], bank, 1'b0, 1'b1));
    wait_done(ch);
    @(negedge clk);
    get_words(ch, x, y);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] rx, ry;
    void'($urandom(32'd2718));

    // reset state
    repeat (2) @(negedge clk);
    hr(ra(0, 4), d); check("R3 ch0 address at reset", 32'(d), 32'h17);
    hr(ra(0, 5), d); check("R3 ch0 control at reset", 32'(d), 32'h08);
    hr(ra(1, 4), d); check("R3 ch1 address at reset", 32'(d), 32'h00);
    hr(ra(1, 5), d); check("R3 ch1 control at reset", 32'(d), 32'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hr(ra(0, 5), d); check("R6 reset request served once", 32'(d), 32'h00);

    // register map and control readback
    hw(ra(1, 5), 8'hF6);
    hr(ra(1, 5), d); check("R2 control upper bits zero", 32'(d), 32'h06);
    hr(ra(1, 6), d); check("R1 sub 6 reads zero", 32'(d), 32'h00);
    hr(ra(1, 7), d); check("R1 sub 7 reads zero", 32'(d), 32'h00);
    hw(ra(1, 4), 8'hA5);
    hr(ra(1, 4), d); check("R1 address byte readback", 32'(d), 32'hA5);

    // request timing on a write
    load_words(0, 16'h1234, 16'h5678);
    hw(ra(0, 4), 8'h40);
    hw(ra(0, 5), ctl(1'b0, 1'b0, 1'b1, 1'b1));
    hr(ra(0, 5), d); check("R6 request set half cycle later", 32'(d[3]), 32'd1);
    @(negedge clk);
    hr(ra(0, 5), d); check("R6 request set while busy", 32'(d[3]), 32'd1);
    @(negedge clk);
    hr(ra(0, 5), d); check("R6 request cleared on completion", 32'(d), 32'h04);
    mdl_x[0][9'h040] = 16'h1234; mdl_y[0][9'h040] = 16'h5678; mdl_ok[0][9'h040] = 1'b1;
    mem_read(1, 1'b0, 9'h040, rx, ry);
    check("R4 R9 X word via other channel", 32'(rx), 32'h1234);
    check("R4 R9 Y word via other channel", 32'(ry), 32'h5678);

    // extension bit is the top address bit
    mem_write(0, 1'b0, 9'h055, 16'hAAAA, 16'h1111);
    mem_write(0, 1'b0, 9'h155, 16'hBBBB, 16'h2222);
    mem_read(1, 1'b0, 9'h055, rx, ry);
    check("R8 low location X", 32'(rx), 32'hAAAA);
    mem_read(1, 1'b0, 9'h155, rx, ry);
    check("R8 high location Y", 32'(ry), 32'h2222);

    // banks are separate
    mem_write(1, 1'b0, 9'h0C3, 16'hC0DE, 16'hD00D);
    mem_write(1, 1'b1, 9'h0C3, 16'hFACE, 16'hBEEF);
    mem_read(0, 1'b0, 9'h0C3, rx, ry);
    check("R7 data bank X", 32'(rx), 32'hC0DE);
    mem_read(0, 1'b1, 9'h0C3, rx, ry);
    check("R7 coefficient bank X", 32'(rx), 32'hFACE);
    check("R5 coefficient bank Y", 32'(ry), 32'hBEEF);

    // no request, no memory traffic
    load_words(0, 16'h9999, 16'h8888);
    hw(ra(0, 4), 8'hC3);
    hw(ra(0, 5), ctl(1'b0, 1'b1, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    mem_read(1, 1'b1, 9'h0C3, rx, ry);
    check("R12 memory untouched without request", 32'(rx), 32'hFACE);

    // both pending together: ch1 armed, ch0 armed, ch1 re-armed on completion
    mem_write(1, 1'b1, 9'h1A3, 16'h0D0D, 16'h0E0E);
    load_words(0, 16'h7E57, 16'h600D);
    hw(ra(0, 4), 8'hA3);
    hw(ra(1, 4), 8'hA3);
    hw(ra(1, 5), ctl(1'b1, 1'b1, 1'b0, 1'b1));
    hw(ra(0, 5), ctl(1'b1, 1'b1, 1'b1, 1'b1));
    hw(ra(1, 5), ctl(1'b1, 1'b1, 1'b0, 1'b1));
    hr(ra(1, 5), d); check("R11 re-arm beats hardware clear", 32'(d[3]), 32'd1);
    hr(ra(0, 5), d); check("R10 ch0 pending", 32'(d[3]), 32'd1);
    @(negedge clk);
    @(negedge clk);
    hr(ra(0, 5), d); check("R10 ch0 served first", 32'(d[3]), 32'd0);
    hr(ra(1, 5), d); check("R10 ch1 still waiting", 32'(d[3]), 32'd1);
    @(negedge clk);
    @(negedge clk);
    hr(ra(1, 5), d); check("R10 ch1 served next", 32'(d[3]), 32'd0);
    get_words(1, rx, ry);
    check("R10 ch1 sees ch0 write X", 32'(rx), 32'h7E57);
    check("R10 ch1 sees ch0 write Y", 32'(ry), 32'h600D);
    mdl_x[1][9'h1A3] = 16'h7E57; mdl_y[1][9'h1A3] = 16'h600D;
    @(negedge clk);

    // random mix against the model
    for (int it = 0; it < 300; it++) begin
      int          ch;
      bit          bank;
      logic [8:0]  a;
      logic [15:0] x, y;
      ch   = int'($urandom % 2);
      bank = 1'($urandom % 2);
      a    = {1'($urandom % 2), 8'(($urandom % 8) * 37)};
      if (mdl_ok[bank][a] && ($urandom % 2) == 1) begin
        mem_read(ch, bank, a, x, y);
        check("R5 random read X", 32'(x), 32'(mdl_x[bank][a]));
        check("R5 random read Y", 32'(y), 32'(mdl_y[bank][a]));
      end else begin
        x = 16'($urandom);
        y = 16'($urandom);
        mem_write(ch, bank, a, x, y);
      end
    end

    summary();
  end
endmodule